// File: doc/BRIEF.md
# Supply Voltage Crossing Detector

This block sits between an analog supply comparator and the interrupt and wake fabric of a chip. It holds the threshold-select code that steers the comparator and an on/off control. It brings the comparator's asynchronous output into the clock domain and reports it as a level flag. Software arms the block by writing a mode word. That word chooses which crossing directions are captured and whether captured crossings raise an interrupt line, a single-cycle event pulse, or both.

Upward and downward crossings latch into two separate pending flags. Each flag stays set until software writes a one to its clear strobe. The power controller tells the block the present low-power state. Detection keeps running in run mode and in the three shallower stop states. It is frozen in the deepest stop state, where the comparator cannot be trusted.

Top module: `vdet_edge_unit`

## Requirements
- R1: After a synchronous active-low reset, the threshold code is 0, detection is off, the mode word is 0, and the level flag, both pending flags, the interrupt and the event pulse are all 0.
- R2: A configuration write replaces the threshold code and the whole 4-bit mode word in the next cycle. Mode bit 0 arms upward crossings, bit 1 arms downward crossings, bit 2 enables the interrupt and bit 3 enables the event pulse. Bits left 0 by the write are cleared. Threshold code 7 selects the external input, and the external-select output is high only for that code.
- R3: While detection is on, the level flag equals the comparator input delayed by a two-stage synchronizer, so it follows the input two clock edges later. While detection is off, the level flag reads 0.
- R4: A 0-to-1 change of the synchronized input while mode bit 0 is set sets the upward pending flag on the third clock edge after the input changes. With bit 0 clear, the flag does not set.
- R5: A 1-to-0 change of the synchronized input while mode bit 1 is set sets the downward pending flag on the third clock edge. With bit 1 clear, the flag does not set.
- R6: A clear strobe drops its pending flag on the next edge. If a new crossing sets the same flag in the same cycle as the clear, the flag stays set.
- R7: The interrupt output is high exactly when mode bit 2 is set and at least one pending flag is set.
- R8: When mode bit 3 is set, an armed crossing produces an event pulse one cycle wide, in the same cycle the pending flag becomes visible.
- R9: With detection off, or with the low-power state code equal to 4 (deepest stop), crossings set no flag and produce no event. State codes 0 to 3 (run, stop 0, stop 1, stop 2) leave detection working.
- R10: A configuration write does not clear pending flags. A later write that drops mode bit 2 removes the interrupt while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_level | input | 3 | Threshold code to load |
| cfg_mode | input | 4 | Mode word to load (rise, fall, irq, event) |
| en_wr | input | 1 | Detection on/off write strobe |
| en_val | input | 1 | Detection on/off value |
| lp_state | input | 3 | Current low-power state code |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| clr_rise | input | 1 | Write-one clear of the upward pending flag |
| clr_fall | input | 1 | Write-one clear of the downward pending flag |
| thresh_sel | output | 3 | Threshold code driven to the comparator |
| ext_ref_sel | output | 1 | High when the external input is selected |
| det_on | output | 1 | Detection enable state |
| cfg_mode_q | output | 4 | Current mode word |
| level_above | output | 1 | Synchronized level flag |
| rise_pend | output | 1 | Upward crossing pending |
| fall_pend | output | 1 | Downward crossing pending |
| irq | output | 1 | Interrupt request |
| evt_pulse | output | 1 | Single-cycle event pulse |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a deepest-stop code of 4. These values fix the crossing-to-flag latency at three edges, so every table step samples at an exact, known cycle. With the default stop code, the bench can hold the low-power input at 4 to show suppression and at 3 to show that detection survives. The table covers every mode-bit combination that matters: edges armed but not reported, reported but not armed, and both.

// File: rtl/vdet_pkg.sv
// Package: shared widths, mode-word bit positions and low-power state codes
// for the supply voltage crossing detector.
package vdet_pkg;
    localparam int LVL_W  = 3;
    localparam int MODE_W = 4;
    localparam int LP_W   = 3;

    // Mode word bit positions; software relies on these.
    localparam int M_RISE = 0;
    localparam int M_FALL = 1;
    localparam int M_IRQ  = 2;
    localparam int M_EVT  = 3;

    // Threshold code that routes the external input to the comparator.
    localparam logic [LVL_W-1:0] EXT_CODE = 3'd7;

    typedef enum logic [LP_W-1:0] {
        LP_RUN      = 3'd0,
        LP_STOP0    = 3'd1,
        LP_STOP1    = 3'd2,
        LP_STOP2    = 3'd3,
        LP_STOP3    = 3'd4,
        LP_STANDBY  = 3'd5,
        LP_SHUTDOWN = 3'd6
    } lp_state_e;
endpackage

// File: rtl/vdet_sync.sv
// Module: vdet_sync
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: the input is quasi-static compared with the clock; STAGES >= 2.
module vdet_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vdet_cfg_regs.sv
// Module: vdet_cfg_regs
// Holds the threshold code, the mode word and the on/off control.
// A configuration write replaces level and mode as a whole, so any mode
// bit not requested is cleared. Assumes single-cycle write strobes.
module vdet_cfg_regs
    import vdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              en_wr,
    input  logic              en_val,
    output logic [LVL_W-1:0]  level_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              en_q
);
    // Load threshold code and mode word together on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            mode_q  <= '0;
        end else if (cfg_wr) begin
            level_q <= cfg_level;
            mode_q  <= cfg_mode;
        end
    end

    // Track the detection on/off control.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_val;
    end
endmodule

// File: rtl/vdet_edge_det.sv
// Module: vdet_edge_det
// Finds crossings on the synchronized comparator level and qualifies them
// with the on/off control, the low-power state and the per-direction arms.
// Emits combinational hit strobes and a registered event pulse.
// Assumes: level_sync already lies in the clock domain.
module vdet_edge_det
    import vdet_pkg::*;
#(
    parameter logic [LP_W-1:0] DEEP_CODE = LP_STOP3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_sync,
    input  logic              en,
    input  logic [LP_W-1:0]   lp_state,
    input  logic [MODE_W-1:0] mode,
    output logic              rise_hit,
    output logic              fall_hit,
    output logic              evt_q
);
    logic prev_q;
    logic active;

    // Remember the previous level even while inactive, so re-arming makes no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_sync;
    end

    // Detection runs only when on and not in the deepest stop state.
    always_comb begin
        active   = en && (lp_state != DEEP_CODE);
        rise_hit = active && mode[M_RISE] &&  level_sync && !prev_q;
        fall_hit = active && mode[M_FALL] && !level_sync &&  prev_q;
    end

    // Register a one-cycle event pulse for any armed crossing when events are enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= mode[M_EVT] && (rise_hit || fall_hit);
    end
endmodule

// File: rtl/vdet_pend_flags.sv
// Module: vdet_pend_flags
// Bank of sticky pending flags with write-one-to-clear.
// A set in the same cycle as a clear wins. Assumes strobes are one cycle wide.
module vdet_pend_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold the flag until cleared; a new set overrides the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= set_i[g] || (pend_q[g] && !clr_i[g]);
        end
    end
endmodule

// File: rtl/vdet_edge_unit.sv
// Module: vdet_edge_unit (top)
// Supply voltage crossing detector: configuration, synchronizer, crossing
// detection, pending flags, interrupt and event outputs.
// Assumes: cmp_in is asynchronous; all other inputs are synchronous to clk.
module vdet_edge_unit
    import vdet_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [LP_W-1:0] DEEP_CODE   = LP_STOP3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic [LP_W-1:0]   lp_state,
    input  logic              cmp_in,
    input  logic              clr_rise,
    input  logic              clr_fall,
    output logic [LVL_W-1:0]  thresh_sel,
    output logic              ext_ref_sel,
    output logic              det_on,
    output logic [MODE_W-1:0] cfg_mode_q,
    output logic              level_above,
    output logic              rise_pend,
    output logic              fall_pend,
    output logic              irq,
    output logic              evt_pulse
);
    localparam int NFLAG = 2;

    logic             level_sync;
    logic             rise_hit, fall_hit;
    logic [NFLAG-1:0] pend_q;

    vdet_cfg_regs i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_level (cfg_level),
        .cfg_mode  (cfg_mode),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .level_q   (thresh_sel),
        .mode_q    (cfg_mode_q),
        .en_q      (det_on)
    );

    vdet_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_in),
        .q_sync  (level_sync)
    );

    vdet_edge_det #(.DEEP_CODE(DEEP_CODE)) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_sync (level_sync),
        .en         (det_on),
        .lp_state   (lp_state),
        .mode       (cfg_mode_q),
        .rise_hit   (rise_hit),
        .fall_hit   (fall_hit),
        .evt_q      (evt_pulse)
    );

    vdet_pend_flags #(.N(NFLAG)) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({fall_hit, rise_hit}),
        .clr_i  ({clr_fall, clr_rise}),
        .pend_q (pend_q)
    );

    // Decode the external-input code and combine pending flags into the interrupt.
    always_comb begin
        ext_ref_sel = (thresh_sel == EXT_CODE);
        level_above = det_on && level_sync;
        rise_pend   = pend_q[0];
        fall_pend   = pend_q[1];
        irq         = cfg_mode_q[M_IRQ] && (|pend_q);
    end
endmodule

// File: rtl/vdet_edge_unit_chk.sv
// Module: vdet_edge_unit_chk
// Property checker for vdet_edge_unit, attached through bind.
module vdet_edge_unit_chk
    import vdet_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [LVL_W-1:0]  cfg_level,
    input logic [MODE_W-1:0] cfg_mode,
    input logic              det_on,
    input logic [LP_W-1:0]   lp_state,
    input logic              clr_rise,
    input logic              clr_fall,
    input logic [LVL_W-1:0]  thresh_sel,
    input logic [MODE_W-1:0] cfg_mode_q,
    input logic              rise_pend,
    input logic              fall_pend,
    input logic              irq,
    input logic              evt_pulse
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (!rise_pend && !fall_pend && !irq && !evt_pulse && thresh_sel == '0));

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr)) |-> (thresh_sel == $past(cfg_level) && cfg_mode_q == $past(cfg_mode)));

    assert_clear_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(rise_pend)) |-> $past(clr_rise));

    assert_fall_clear_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(fall_pend)) |-> $past(clr_fall));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rise_pend || fall_pend) && cfg_mode_q[M_IRQ]));

    assert_evt_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && evt_pulse) |-> $past(cfg_mode_q[M_EVT]));

    assert_deep_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rise_pend)) |-> ($past(det_on) && $past(lp_state) != LP_STOP3));
endmodule

bind vdet_edge_unit vdet_edge_unit_chk i_chk (.*);

// File: tb/test_vdet_edge_unit.sv
module test_vdet_edge_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_level = '0;
    logic [3:0] cfg_mode = '0;
    logic       en_wr = 1'b0, en_val = 1'b0;
    logic [2:0] lp_state = '0;
    logic       cmp_in = 1'b0;
    logic       clr_rise = 1'b0, clr_fall = 1'b0;
    logic [2:0] thresh_sel;
    logic       ext_ref_sel, det_on, level_above, rise_pend, fall_pend, irq, evt_pulse;
    logic [3:0] cfg_mode_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vdet_edge_unit i_vdet_edge_unit (.*);

    // Vector fields: {mode[3:0], cmp, exp_rise, exp_fall, exp_evt, exp_irq}
    localparam logic [8:0] VEC [8] = '{
        {4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'b0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'b0101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'b1010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'b1100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'b0011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [2:0] lvl, input logic [3:0] mode);
        cfg_wr = 1'b1; cfg_level = lvl; cfg_mode = mode;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_both();
        clr_rise = 1'b1; clr_fall = 1'b1;
        step(1);
        clr_rise = 1'b0; clr_fall = 1'b0;
    endtask

    initial begin
        step(3);
        // R1: reset state
        check("R1 thresh", thresh_sel, 0);
        check("R1 outs", {det_on, cfg_mode_q, level_above, rise_pend, fall_pend, irq, evt_pulse}, 0);
        rst_n = 1'b1;
        step(1);

        // R2: configuration load and external-select decode
        write_cfg(3'd7, 4'b0000);
        check("R2 level", thresh_sel, 7);
        check("R2 ext", ext_ref_sel, 1);
        write_cfg(3'd3, 4'b0000);
        check("R2 ext off", ext_ref_sel, 0);

        // R3: level flag gated by enable, two-edge latency
        cmp_in = 1'b1;
        step(3);
        check("R3 off reads 0", level_above, 0);
        en_wr = 1'b1; en_val = 1'b1;
        step(1);
        en_wr = 1'b0;
        check("R3 on level", level_above, 1);
        cmp_in = 1'b0;
        step(1);
        check("R3 one edge", level_above, 1);
        step(1);
        check("R3 two edges", level_above, 0);
        step(2);

        // R4 R5 R7 R8 R2: table walk
        for (int i = 0; i < 8; i++) begin
            write_cfg(3'd2, VEC[i][8:5]);
            check("R2 mode", cfg_mode_q, VEC[i][8:5]);
            cmp_in = VEC[i][4];
            step(3);
            check("R4 rise pend", rise_pend, VEC[i][3]);
            check("R5 fall pend", fall_pend, VEC[i][2]);
            check("R8 evt", evt_pulse, VEC[i][1]);
            check("R7 irq", irq, VEC[i][0]);
            step(1);
            check("R8 evt one cycle", evt_pulse, 0);
            clear_both();
            check("R6 cleared", {rise_pend, fall_pend}, 0);
        end
        // cmp_in is now 1

        // R6: set wins over simultaneous clear
        write_cfg(3'd2, 4'b0011);
        cmp_in = 1'b0;
        step(2);
        clr_fall = 1'b1;
        step(1);
        clr_fall = 1'b0;
        check("R6 set wins", fall_pend, 1);
        clear_both();

        // R10: reconfig keeps flag, drops irq
        write_cfg(3'd2, 4'b0101);
        cmp_in = 1'b1;
        step(3);
        check("R10 irq before", irq, 1);
        write_cfg(3'd2, 4'b0001);
        check("R10 irq dropped", irq, 0);
        check("R10 flag kept", rise_pend, 1);
        clear_both();

        // R9: deepest stop suppresses
        write_cfg(3'd2, 4'b1011);
        lp_state = 3'd4;
        cmp_in = 1'b0;
        step(3);
        check("R9 deep no flag", fall_pend, 0);
        check("R9 deep no evt", evt_pulse, 0);
        // R9: stop 2 still detects
        lp_state = 3'd3;
        cmp_in = 1'b1;
        step(3);
        check("R9 stop2 flag", rise_pend, 1);
        check("R9 stop2 evt", evt_pulse, 1);
        clear_both();
        // R9: detection off suppresses
        lp_state = 3'd0;
        en_wr = 1'b1; en_val = 1'b0;
        step(1);
        en_wr = 1'b0;
        cmp_in = 1'b0;
        step(3);
        check("R9 off no flag", fall_pend, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule